// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block runs the power-on initialisation and the periodic refresh of an asynchronous DRAM that counts its own refresh rows. After reset it waits out a power-up pause measured in clock cycles. It then asks the access controller for the strobes and issues a burst of wake-up cycles. Each wake-up cycle is a CAS-before-RAS cycle. Once that burst ends, the sequencer raises `ready_o`.

From then on a free-running interval timer marks when each refresh is due. For the default figures this is every 16 ms / 1024 rows, about 15.6 us. When a refresh is due, the sequencer raises `rfsh_req_o`. The access controller answers with `rfsh_gnt_i` once it has closed its open row. While the grant is held, the sequencer owns the RAS and CAS strobes. It pulls CAS low first and RAS low after it. Write enable and output enable stay inactive, so the data bus remains high-impedance. No row address is produced, because the device supplies it internally.

If a refresh waits longer than a configurable slack without being granted, the sequencer raises a sticky `late_o` flag and drops `ready_o`. The next grant then carries a full wake-up burst in place of a single refresh, and `ready_o` rises again afterwards.

Top module: `dram_refresh_sequencer`

## Requirements
- R1: While reset is held and right after it, `rfsh_req_o`, `own_o`, `ready_o` and `late_o` are 0, and `ras_n_o` and `cas_n_o` are 1.
- R2: `rfsh_req_o` stays 0 for the first PAUSE_CYC-1 clock edges after reset release. It reads 1 after edge number PAUSE_CYC, where PAUSE_CYC = CLK_MHZ*PAUSE_US.
- R3: The first grant produces exactly WAKE_CYCLES CAS-before-RAS cycles, with `ready_o` still 0. Then `rfsh_req_o` falls. `ready_o` becomes 1 on the clock edge that first samples `rfsh_gnt_i` low after that.
- R4: Each strobe cycle follows a fixed sequence:
  - CAS goes low exactly LEAD_CYC cycles before RAS.
  - RAS stays low for ACT_CYC cycles.
  - CAS rises together with RAS.
  - CAS stays high for at least PRE_CYC cycles before it falls again.
  - RAS never falls while CAS is high.
- R5: `we_n_o` and `oe_n_o` are 1 in every cycle.
- R6: The strobes are low only while `own_o` is 1. `own_o` is 1 only while `rfsh_gnt_i` is 1. `rfsh_req_o` stays 1 for as long as `own_o` is 1.
- R7: When every refresh is finished within the interval:
  - Request k (k = 1, 2, ...) rises exactly k*INTERVAL_CYC+1 cycles after `ready_o` rose, where INTERVAL_CYC = CLK_MHZ*REFRESH_NS/1000.
  - Each such grant produces exactly one CAS-before-RAS cycle.
- R8: An interval expiry can fall in the same cycle as the last precharge cycle of a refresh. In that case the new refresh is kept: `rfsh_req_o` rises again two cycles after the grant is released.
- R9: If a request is not granted, `late_o` rises SLACK_CYC-1 cycles after `rfsh_req_o` rose, and `ready_o` falls on the same edge. `late_o` then stays 1 until reset.
- R10: After a missed deadline, the next grant produces WAKE_CYCLES CAS-before-RAS cycles. `ready_o` returns to 1 once that grant is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rfsh_req_o | output | 1 | Sequencer asks for the DRAM strobes |
| rfsh_gnt_i | input | 1 | Access controller has closed its row and hands over the strobes |
| own_o | output | 1 | Sequencer is driving the strobes (select for the strobe multiplexer) |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, held inactive |
| oe_n_o | output | 1 | Output enable, held inactive |
| ready_o | output | 1 | Initialisation complete and no wake-up outstanding |
| late_o | output | 1 | Sticky: a refresh waited longer than the slack |

## Verification
The interval timer's expiry and the clearing of the pending refresh at the end of a refresh burst can land in the same cycle. The bench provokes this by holding back the grant by INTERVAL_CYC-18 cycles, so that the final precharge cycle falls exactly on the next expiry. It judges the result at the ports. The pending refresh must survive: a fresh request must appear two cycles after the grant is dropped, and it must yield exactly one more refresh cycle. The other cases are as follows. Random grant delays check the fixed request cadence. A withheld grant checks the exact cycle at which the late flag rises, and that a full wake-up burst follows.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [2:0] {
        SQ_PAUSE,
        SQ_REQ,
        SQ_RUN,
        SQ_REL,
        SQ_IDLE
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LEAD,
        PH_ACTIVE,
        PH_PRECH
    } pulse_phase_e;

endpackage

// File: rtl/rfsh_pulse_gen.sv
module rfsh_pulse_gen
    import dram_rfsh_pkg::*;
#(
    parameter int LEAD_CYC = 2,
    parameter int ACT_CYC  = 8,
    parameter int PRE_CYC  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic done_o,
    output logic ras_n_o,
    output logic cas_n_o
);

    localparam int MAX_A = (LEAD_CYC > ACT_CYC) ? LEAD_CYC : ACT_CYC;
    localparam int MAX_C = (MAX_A > PRE_CYC) ? MAX_A : PRE_CYC;
    localparam int CW    = $clog2(MAX_C + 1);

    typedef struct packed {
        pulse_phase_e  phase;
        logic [CW-1:0] cnt;
    } pg_regs_t;

    pg_regs_t q, d;

    always_comb begin
        d      = q;
        done_o = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    d.phase = PH_LEAD;
                    d.cnt   = '0;
                end
            end
            PH_LEAD: begin
                if (q.cnt == CW'(LEAD_CYC - 1)) begin
                    d.phase = PH_ACTIVE;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            PH_ACTIVE: begin
                if (q.cnt == CW'(ACT_CYC - 1)) begin
                    d.phase = PH_PRECH;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            PH_PRECH: begin
                if (q.cnt == CW'(PRE_CYC - 1)) begin
                    done_o  = 1'b1;
                    d.cnt   = '0;
                    d.phase = start_i ? PH_LEAD : PH_IDLE;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.phase <= PH_IDLE;
            q.cnt   <= '0;
        end else begin
            q <= d;
        end
    end

    assign cas_n_o = !((q.phase == PH_LEAD) || (q.phase == PH_ACTIVE));
    assign ras_n_o = !(q.phase == PH_ACTIVE);

    // R4: the row strobe only falls after the column strobe is already low
    p_cas_leads_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> ($past(cas_n_o) == 1'b0));

    // R4: both strobes return high together
    p_strobes_rise_together_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |-> cas_n_o);

endmodule

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int INTERVAL_CYC = 1562,
    parameter int SLACK_CYC    = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic serving_i,
    input  logic clr_i,
    output logic pending_o,
    output logic miss_o
);

    localparam int IW = $clog2(INTERVAL_CYC + 1);
    localparam int SW = $clog2(SLACK_CYC + 1);

    typedef struct packed {
        logic [IW-1:0] cnt;
        logic          pending;
        logic [SW-1:0] wait_cnt;
        logic          seen;
    } tm_regs_t;

    tm_regs_t q, d;
    logic     tick;
    logic     waiting;

    assign tick    = en_i && (q.cnt == IW'(INTERVAL_CYC - 1));
    assign waiting = q.pending && !serving_i && !q.seen;
    assign miss_o  = waiting && (q.wait_cnt == SW'(SLACK_CYC - 1));

    always_comb begin
        d = q;
        if (en_i) begin
            d.cnt = tick ? '0 : q.cnt + IW'(1);
        end
        if (waiting) begin
            if (miss_o) begin
                d.seen = 1'b1;
            end else begin
                d.wait_cnt = q.wait_cnt + SW'(1);
            end
        end
        if (clr_i) begin
            d.pending  = 1'b0;
            d.wait_cnt = '0;
            d.seen     = 1'b0;
        end
        // an expiry in the same cycle as a clear opens a new pending refresh
        if (tick) begin
            d.pending = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt      <= '0;
            q.pending  <= 1'b0;
            q.wait_cnt <= '0;
            q.seen     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pending_o = q.pending;

    // R8: a pending refresh is only ever dropped by a clear
    p_pending_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !clr_i) |=> pending_o);

    // R9: the wait counter never passes the slack limit
    p_wait_capped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.wait_cnt <= SW'(SLACK_CYC - 1));

endmodule

// File: rtl/dram_refresh_sequencer.sv
module dram_refresh_sequencer
    import dram_rfsh_pkg::*;
#(
    parameter int CLK_MHZ     = 100,
    parameter int PAUSE_US    = 200,
    parameter int REFRESH_NS  = 15625,
    parameter int SLACK_CYC   = 1000,
    parameter int LEAD_CYC    = 2,
    parameter int ACT_CYC     = 8,
    parameter int PRE_CYC     = 6,
    parameter int WAKE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic rfsh_req_o,
    input  logic rfsh_gnt_i,
    output logic own_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic we_n_o,
    output logic oe_n_o,
    output logic ready_o,
    output logic late_o
);

    localparam int PAUSE_CYC    = CLK_MHZ * PAUSE_US;
    localparam int INTERVAL_CYC = (CLK_MHZ * REFRESH_NS) / 1000;
    localparam int PW           = $clog2(PAUSE_CYC + 1);
    localparam int BW           = $clog2(WAKE_CYCLES + 1);

    typedef struct packed {
        seq_state_e    state;
        logic [PW-1:0] pcnt;
        logic [BW-1:0] rem;
        logic          rewake;
        logic          ready;
        logic          booted;
        logic          late;
    } sq_regs_t;

    sq_regs_t q, d;
    logic     pg_start;
    logic     pg_done;
    logic     rf_clr;
    logic     rf_pending;
    logic     rf_miss;

    rfsh_interval_timer #(
        .INTERVAL_CYC(INTERVAL_CYC),
        .SLACK_CYC   (SLACK_CYC)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (q.booted),
        .serving_i(own_o),
        .clr_i    (rf_clr),
        .pending_o(rf_pending),
        .miss_o   (rf_miss)
    );

    rfsh_pulse_gen #(
        .LEAD_CYC(LEAD_CYC),
        .ACT_CYC (ACT_CYC),
        .PRE_CYC (PRE_CYC)
    ) i_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(pg_start),
        .done_o (pg_done),
        .ras_n_o(ras_n_o),
        .cas_n_o(cas_n_o)
    );

    always_comb begin
        d        = q;
        pg_start = 1'b0;
        rf_clr   = 1'b0;
        unique case (q.state)
            SQ_PAUSE: begin
                if (q.pcnt == PW'(PAUSE_CYC - 1)) begin
                    d.state = SQ_REQ;
                    d.rem   = BW'(WAKE_CYCLES);
                end else begin
                    d.pcnt = q.pcnt + PW'(1);
                end
            end
            SQ_IDLE: begin
                if (rf_pending) begin
                    d.state = SQ_REQ;
                    d.rem   = BW'(1);
                end
            end
            SQ_REQ: begin
                if (rf_miss || q.rewake) begin
                    d.rem    = BW'(WAKE_CYCLES);
                    d.rewake = 1'b0;
                end
                if (rfsh_gnt_i) begin
                    d.state  = SQ_RUN;
                    pg_start = 1'b1;
                end
            end
            SQ_RUN: begin
                if (pg_done) begin
                    if (q.rem == BW'(1)) begin
                        rf_clr  = 1'b1;
                        d.rem   = '0;
                        d.state = SQ_REL;
                    end else begin
                        d.rem    = q.rem - BW'(1);
                        pg_start = 1'b1;
                    end
                end
            end
            SQ_REL: begin
                if (!rfsh_gnt_i) begin
                    d.state  = SQ_IDLE;
                    d.ready  = 1'b1;
                    d.booted = 1'b1;
                end
            end
            default: d.state = SQ_PAUSE;
        endcase
        if (rf_miss) begin
            d.late  = 1'b1;
            d.ready = 1'b0;
            if (q.state != SQ_REQ) begin
                d.rewake = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state  <= SQ_PAUSE;
            q.pcnt   <= '0;
            q.rem    <= '0;
            q.rewake <= 1'b0;
            q.ready  <= 1'b0;
            q.booted <= 1'b0;
            q.late   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rfsh_req_o = (q.state == SQ_REQ) || (q.state == SQ_RUN);
    assign own_o      = (q.state == SQ_RUN);
    assign we_n_o     = 1'b1;
    assign oe_n_o     = 1'b1;
    assign ready_o    = q.ready;
    assign late_o     = q.late;

    // R6: strobes move only while the sequencer owns them
    p_strobe_owned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n_o || !cas_n_o) |-> own_o);

    // R6: ownership only under a held grant
    p_own_granted_r6: assert property (@(posedge clk) disable iff (!rst_n)
        own_o |-> rfsh_gnt_i);

    // R9: the late flag never clears without reset
    p_late_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        late_o |=> late_o);

    // R9: a missed deadline withdraws readiness on the same edge
    p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(late_o) |-> !ready_o);

endmodule

// File: tb/test_dram_refresh_sequencer.sv
`timescale 1ns/1ps
module test_dram_refresh_sequencer;

    localparam int CLK_MHZ    = 200;
    localparam int PAUSE_US   = 1;
    localparam int REFRESH_NS = 1000;
    localparam int SLACK      = 190;
    localparam int LEAD       = 2;
    localparam int ACT        = 8;
    localparam int PRE        = 6;
    localparam int WAKE       = 8;
    localparam int PAUSE      = CLK_MHZ * PAUSE_US;
    localparam int INTERVAL   = (CLK_MHZ * REFRESH_NS) / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b0;
    logic req, own, ras_n, cas_n, we_n, oe_n, ready, late;

    int  checks = 0;
    int  fails = 0;
    int  cyc = 0;
    int  cbr_cnt = 0;
    bit  finished = 1'b0;
    bit  bad_weoe = 1'b0;
    bit  bad_own = 1'b0;
    bit  bad_gnt = 1'b0;
    bit  bad_hold = 1'b0;

    always #2.5 clk = ~clk;

    dram_refresh_sequencer #(
        .CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .REFRESH_NS(REFRESH_NS),
        .SLACK_CYC(SLACK), .LEAD_CYC(LEAD), .ACT_CYC(ACT), .PRE_CYC(PRE),
        .WAKE_CYCLES(WAKE)
    ) i_dram_refresh_sequencer (
        .clk(clk), .rst_n(rst_n), .rfsh_req_o(req), .rfsh_gnt_i(gnt),
        .own_o(own), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
        .oe_n_o(oe_n), .ready_o(ready), .late_o(late)
    );

    function automatic int exp_req_cycle(input int t_ready, input int k);
        return t_ready + k * INTERVAL + 1;
    endfunction

    function automatic int exp_cbr(input bit wake);
        return wake ? WAKE : 1;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // strobe monitor
    int  cas_run = 0, ras_run = 0, high_run = 100;
    logic prev_ras = 1'b1, prev_cas = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ras && !ras_n) begin
                cbr_cnt++;
                check(!cas_n && cas_run == LEAD, "R4 cas lead", cas_run, LEAD);
            end
            if (!prev_ras && ras_n) begin
                check(ras_run == ACT, "R4 ras width", ras_run, ACT);
                check(cas_n == 1'b1, "R4 cas rises with ras", cas_n, 1);
            end
            if (prev_cas && !cas_n)
                check(high_run >= PRE, "R4 precharge", high_run, PRE);
            if (!(we_n && oe_n)) bad_weoe = 1'b1;
            if ((!ras_n || !cas_n) && !own) bad_own = 1'b1;
            if (own && !gnt) bad_gnt = 1'b1;
            if (own && !req) bad_hold = 1'b1;
            cas_run  = cas_n ? 0 : cas_run + 1;
            ras_run  = ras_n ? 0 : ras_run + 1;
            high_run = cas_n ? high_run + 1 : 0;
            prev_ras = ras_n;
            prev_cas = cas_n;
        end
    end

    task automatic serve(input int dly, input int rel_dly);
        repeat (dly) @(negedge clk);
        cbr_cnt = 0;
        gnt = 1'b1;
        while (req) @(negedge clk);
        repeat (rel_dly) @(negedge clk);
        gnt = 1'b0;
    endtask

    initial begin
        int t_ready;
        int t_req;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        check(!req && !own && !ready && !late && ras_n && cas_n, "R1 reset state",
              {req, own, ready, late, ras_n, cas_n}, 6'b000011);
        rst_n = 1'b1;
        while (cyc < PAUSE - 1) @(negedge clk);
        check(!req, "R2 no request during pause", req, 0);
        @(negedge clk);
        check(req, "R2 request after pause", req, 1);

        // R3 wake-up burst
        serve($urandom_range(0, 5), 0);
        check(cbr_cnt == exp_cbr(1), "R3 wake-up cycle count", cbr_cnt, WAKE);
        check(!ready, "R3 ready low before release", ready, 0);
        @(negedge clk);
        check(ready, "R3 ready after release", ready, 1);
        t_ready = cyc;

        // R7 random grant delays, fixed cadence
        for (int k = 1; k <= 6; k++) begin
            while (!req) @(negedge clk);
            t_req = cyc;
            check(t_req == exp_req_cycle(t_ready, k), "R7 request cadence",
                  t_req, exp_req_cycle(t_ready, k));
            serve($urandom_range(0, 20), $urandom_range(0, 3));
            check(cbr_cnt == exp_cbr(0), "R7 one refresh per grant", cbr_cnt, 1);
            check(!late && ready, "R9 no false late flag", late, 0);
        end

        // R8 expiry in the cycle the refresh finishes
        while (!req) @(negedge clk);
        repeat (INTERVAL - 18) @(negedge clk);
        cbr_cnt = 0;
        gnt = 1'b1;
        while (req) @(negedge clk);
        check(cbr_cnt == 1, "R8 refresh before coincidence", cbr_cnt, 1);
        gnt = 1'b0;
        @(negedge clk);
        check(!req, "R8 request low one cycle after release", req, 0);
        @(negedge clk);
        check(req, "R8 pending refresh kept", req, 1);
        serve(0, 0);
        check(cbr_cnt == 1, "R8 kept refresh served once", cbr_cnt, 1);
        check(!late, "R8 no late flag", late, 0);

        // R9 withheld grant
        while (!req) @(negedge clk);
        t_req = cyc;
        while (!late && (cyc - t_req) < 4 * SLACK) @(negedge clk);
        check(late && (cyc - t_req) == SLACK - 1, "R9 late flag timing",
              cyc - t_req, SLACK - 1);
        check(!ready, "R9 ready dropped with late", ready, 0);

        // R10 repeated wake-up
        serve(0, 0);
        check(cbr_cnt == exp_cbr(1), "R10 wake-up repeated", cbr_cnt, WAKE);
        check(!ready, "R10 ready low until release", ready, 0);
        @(negedge clk);
        check(ready, "R10 ready restored", ready, 1);
        check(late, "R9 late flag sticky", late, 1);

        while (!req) @(negedge clk);
        serve($urandom_range(0, 10), 1);
        check(cbr_cnt == 1, "R7 normal refresh after recovery", cbr_cnt, 1);
        repeat (4) @(negedge clk);
        check(late, "R9 late flag still set", late, 1);

        check(!bad_weoe, "R5 write and output enable inactive", bad_weoe, 0);
        check(!bad_own, "R6 strobes only while owned", bad_own, 0);
        check(!bad_gnt, "R6 ownership only under grant", bad_gnt, 0);
        check(!bad_hold, "R6 request held while owned", bad_hold, 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule